// File: doc/BRIEF.md
# Hyperchaotic RK4 Keystream Generator

This block advances a four-variable Lorenz-type hyperchaotic system (state x, y, z, w) one fourth-order Runge–Kutta step at a time. All arithmetic is signed 32-bit fixed point with 8 integer bits and 24 fraction bits. Sums and products wrap in two's complement on purpose, so an overflow acts as a modulo and keeps the trajectory bounded. The integration step is deliberately large. Each completed step publishes a 24-bit key word taken from the new x value. The new state is then kept as the starting point of the following step, so every key depends on the whole history since the last load.

A host writes the initial conditions through the load port and then requests steps with a start pulse. A small sequencer runs the four derivative stages and the final update in five clock cycles. It uses one scaling multiplier per state variable. The end of each step is flagged by a single-cycle valid pulse. The constants and the step size are fixed at elaboration through parameters.

Top module: `hc_keygen`

## Requirements
- R1: Every value is a 32-bit two's-complement word read as 8Q24. Additions wrap modulo 2^32. A product of words a and b is bits [55:24] of their 64-bit signed product, wrapped and never saturated.
- R2: For a point (x, y, z, w), the derivative is dx = A(y − x), dy = x(B − z) + w − y, dz = xy − Cz and dw = Dx. The 8Q24 codes are A = 83886080 (5), B = 335544320 (20), C = 44739243 (8/3) and D = −335544320 (−20).
- R3: A step from state s forms k0 = f(s), k1 = f(s + Hh·k0), k2 = f(s + Hh·k1) and k3 = f(s + H·k2). The new state is s + H6·(k0 + 2k1 + 2k2 + k3). The codes are H = 25333596 (1.51), Hh = 12666798 (H/2) and H6 = 4222266 (H/6).
- R4: A start accepted while idle (busy low, load low) makes busy high for exactly the next 5 cycles. In the cycle after the last busy cycle, busy is low, key_valid is high and the state outputs carry the new state.
- R5: key equals bits [23:0] of x_o. While key_valid is high, key is the low 24 bits of the newly computed x.
- R6: Successive steps chain: each step starts from the state left by the previous step.
- R7: A start that arrives while busy is ignored. The running step finishes at its original time with the same result, and no further step follows.
- R8: load copies x0, y0, z0 and w0 into the state in the next cycle. It aborts any step in progress, forces busy and key_valid low in that cycle and wins over a start in the same cycle.
- R9: After reset the state is all zero, busy is low and key_valid is low.
- R10: key_valid is high for exactly one cycle per completed step.
- R11: The state outputs change only in the cycle where key_valid is high or the cycle after a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Load initial conditions, abort any step |
| x0 | input | 32 | Initial x, 8Q24 |
| y0 | input | 32 | Initial y, 8Q24 |
| z0 | input | 32 | Initial z, 8Q24 |
| w0 | input | 32 | Initial w, 8Q24 |
| start | input | 1 | Request one integration step |
| busy | output | 1 | Step in progress |
| key_valid | output | 1 | One-cycle pulse when a new key is ready |
| key | output | 24 | Key word, low bits of x |
| x_o | output | 32 | Current x |
| y_o | output | 32 | Current y |
| z_o | output | 32 | Current z |
| w_o | output | 32 | Current w |

## Verification
The bound checker checks the control timing on every cycle. It checks that a step stays busy for exactly five cycles, that key_valid is a single-cycle pulse, that an accepted start raises busy and a load clears it, that the loaded words appear the cycle after a load, and that the state holds still between updates. Those checks cannot show that the state is numerically right. Only the bench scenarios do that, by comparing each new state and key with a model of the wrapping arithmetic. The scenarios cover chained steps from random and extreme operands that force overflow, a start issued mid-step, and a load that cuts a step short.

// File: rtl/hc_pkg.sv
package hc_pkg;
   localparam int WORD_W = 32;
   localparam int FRAC_W = 24;
   localparam int N_VAR  = 4;

   typedef logic signed [WORD_W-1:0] word_t;
   typedef logic [N_VAR-1:0][WORD_W-1:0] vec_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_K0,
      ST_K1,
      ST_K2,
      ST_K3,
      ST_UPD
   } stage_t;

   // wrapping fixed-point product: 2*WORD_W signed product, drop FRAC_W bits, keep WORD_W
   function automatic word_t fx_mul(input word_t a, input word_t b);
      logic signed [2*WORD_W-1:0] p;
      p = a * b;
      return WORD_W'(p >>> FRAC_W);
   endfunction
endpackage

// File: rtl/hc_deriv.sv
module hc_deriv
   import hc_pkg::*;
#(
   parameter word_t K_A = 32'sd83886080,
   parameter word_t K_B = 32'sd335544320,
   parameter word_t K_C = 32'sd44739243,
   parameter word_t K_D = -32'sd335544320
) (
   input  vec_t pt,
   output vec_t slope
);
   // lane order: 0 = x, 1 = y, 2 = z, 3 = w
   word_t vx, vy, vz, vw;
   assign vx = pt[0];
   assign vy = pt[1];
   assign vz = pt[2];
   assign vw = pt[3];

   for (genvar i = 0; i < N_VAR; i++) begin : g_lane
      if (i == 0) begin : g_x
         assign slope[i] = fx_mul(K_A, vy - vx);
      end else if (i == 1) begin : g_y
         assign slope[i] = fx_mul(vx, K_B - vz) + vw - vy;
      end else if (i == 2) begin : g_z
         assign slope[i] = fx_mul(vx, vy) - fx_mul(K_C, vz);
      end else begin : g_w
         assign slope[i] = fx_mul(K_D, vx);
      end
   end
endmodule

// File: rtl/hc_lane.sv
module hc_lane
   import hc_pkg::*;
#(
   parameter word_t HALF_H  = 32'sd12666798,
   parameter word_t FULL_H  = 32'sd25333596,
   parameter word_t SIXTH_H = 32'sd4222266
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load,
   input  word_t  init,
   input  logic   go,
   input  stage_t stage,
   input  word_t  slope,
   output word_t  cur,
   output word_t  probe
);
   word_t cur_q, probe_q, acc_q;
   word_t coef, opnd, scaled;

   // single multiplier per lane, shared between stage points and final update
   always_comb begin
      coef = HALF_H;
      opnd = slope;
      if (stage == ST_K2) begin
         coef = FULL_H;
      end else if (stage == ST_UPD) begin
         coef = SIXTH_H;
         opnd = acc_q;
      end
      scaled = fx_mul(coef, opnd);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q   <= '0;
         probe_q <= '0;
         acc_q   <= '0;
      end else if (load) begin
         cur_q   <= init;
         probe_q <= init;
         acc_q   <= '0;
      end else if (go) begin
         probe_q <= cur_q;
         acc_q   <= '0;
      end else begin
         case (stage)
            ST_K0: begin
               acc_q   <= slope;
               probe_q <= cur_q + scaled;
            end
            ST_K1, ST_K2: begin
               acc_q   <= acc_q + (slope <<< 1);
               probe_q <= cur_q + scaled;
            end
            ST_K3: begin
               acc_q <= acc_q + slope;
            end
            ST_UPD: begin
               cur_q <= cur_q + scaled;
            end
            default: begin
            end
         endcase
      end
   end

   assign cur   = cur_q;
   assign probe = probe_q;
endmodule

// File: rtl/hc_seq.sv
module hc_seq
   import hc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load,
   input  logic   start,
   output stage_t stage,
   output logic   go,
   output logic   busy,
   output logic   key_valid
);
   stage_t st_q, st_d;
   logic   valid_q;

   assign go = start && (st_q == ST_IDLE) && !load;

   always_comb begin
      case (st_q)
         ST_IDLE: st_d = go ? ST_K0 : ST_IDLE;
         ST_K0:   st_d = ST_K1;
         ST_K1:   st_d = ST_K2;
         ST_K2:   st_d = ST_K3;
         ST_K3:   st_d = ST_UPD;
         ST_UPD:  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
      if (load) st_d = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         valid_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         valid_q <= (st_q == ST_UPD) && !load;
      end
   end

   assign stage     = st_q;
   assign busy      = (st_q != ST_IDLE);
   assign key_valid = valid_q;
endmodule

// File: rtl/hc_keygen.sv
module hc_keygen
   import hc_pkg::*;
#(
   parameter int    KEY_W   = 24,
   parameter word_t K_A     = 32'sd83886080,
   parameter word_t K_B     = 32'sd335544320,
   parameter word_t K_C     = 32'sd44739243,
   parameter word_t K_D     = -32'sd335544320,
   parameter word_t HALF_H  = 32'sd12666798,
   parameter word_t FULL_H  = 32'sd25333596,
   parameter word_t SIXTH_H = 32'sd4222266
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] x0,
   input  logic [WORD_W-1:0] y0,
   input  logic [WORD_W-1:0] z0,
   input  logic [WORD_W-1:0] w0,
   input  logic              start,
   output logic              busy,
   output logic              key_valid,
   output logic [KEY_W-1:0]  key,
   output logic [WORD_W-1:0] x_o,
   output logic [WORD_W-1:0] y_o,
   output logic [WORD_W-1:0] z_o,
   output logic [WORD_W-1:0] w_o
);
   initial begin
      assert (KEY_W > 0 && KEY_W <= WORD_W)
         else $error("hc_keygen: KEY_W must lie in 1..WORD_W");
      assert (FRAC_W > 0 && FRAC_W < WORD_W)
         else $error("hc_keygen: FRAC_W must lie in 1..WORD_W-1");
      assert (N_VAR == 4)
         else $error("hc_keygen: system is defined for four variables");
   end

   stage_t stage;
   logic   go;
   vec_t   init_v, cur_v, probe_v, slope_v;

   assign init_v = {w0, z0, y0, x0};

   hc_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .start     (start),
      .stage     (stage),
      .go        (go),
      .busy      (busy),
      .key_valid (key_valid)
   );

   hc_deriv #(
      .K_A (K_A),
      .K_B (K_B),
      .K_C (K_C),
      .K_D (K_D)
   ) u_deriv (
      .pt    (probe_v),
      .slope (slope_v)
   );

   for (genvar i = 0; i < N_VAR; i++) begin : g_var
      word_t cur_w, probe_w;
      hc_lane #(
         .HALF_H  (HALF_H),
         .FULL_H  (FULL_H),
         .SIXTH_H (SIXTH_H)
      ) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (load),
         .init  (init_v[i]),
         .go    (go),
         .stage (stage),
         .slope (slope_v[i]),
         .cur   (cur_w),
         .probe (probe_w)
      );
      assign cur_v[i]   = cur_w;
      assign probe_v[i] = probe_w;
   end

   assign x_o = cur_v[0];
   assign y_o = cur_v[1];
   assign z_o = cur_v[2];
   assign w_o = cur_v[3];
   assign key = cur_v[0][KEY_W-1:0];
endmodule

// File: rtl/hc_keygen_chk.sv
module hc_keygen_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        load,
   input logic        start,
   input logic [31:0] x0,
   input logic [31:0] w0,
   input logic        busy,
   input logic        key_valid,
   input logic [31:0] x_o,
   input logic [31:0] y_o,
   input logic [31:0] z_o,
   input logic [31:0] w_o
);
   logic [2:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || load || !busy) run_cnt <= '0;
      else                         run_cnt <= run_cnt + 3'd1;
   end

   // R4: never more than five busy cycles in one step
   a_r4_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> run_cnt < 3'd5);

   // R4: a completed step was busy for exactly five cycles
   a_r4_five_cycles: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |-> run_cnt == 3'd5);

   // R4: an accepted start raises busy
   a_r4_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !load) |=> busy);

   // R7: a step is not cut short or restarted by a start while busy
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load) |=> (busy || key_valid));

   // R8: load aborts and idles
   a_r8_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (!busy && !key_valid));

   // R8: loaded words appear next cycle
   a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (x_o == $past(x0) && w_o == $past(w0)));

   // R10: key_valid is a single-cycle pulse
   a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |=> !key_valid);

   // R11: state only moves on an update or a load
   a_r11_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (key_valid || ($stable(x_o) && $stable(y_o) && $stable(z_o) && $stable(w_o))));
endmodule

bind hc_keygen hc_keygen_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load      (load),
   .start     (start),
   .x0        (x0),
   .w0        (w0),
   .busy      (busy),
   .key_valid (key_valid),
   .x_o       (x_o),
   .y_o       (y_o),
   .z_o       (z_o),
   .w_o       (w_o)
);

// File: tb/hc_keygen_tb.sv
module hc_keygen_tb;
   typedef logic [3:0][31:0] v4_t;

   localparam logic signed [31:0] CA = 32'sd83886080;
   localparam logic signed [31:0] CB = 32'sd335544320;
   localparam logic signed [31:0] CC = 32'sd44739243;
   localparam logic signed [31:0] CD = -32'sd335544320;
   localparam logic signed [31:0] CH  = 32'sd25333596;
   localparam logic signed [31:0] CHH = 32'sd12666798;
   localparam logic signed [31:0] CH6 = 32'sd4222266;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic        start = 1'b0;
   logic [31:0] x0 = '0, y0 = '0, z0 = '0, w0 = '0;
   logic        busy, key_valid;
   logic [23:0] key;
   logic [31:0] x_o, y_o, z_o, w_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   v4_t model;

   always #2.5 clk = ~clk;

   hc_keygen u_dut (
      .clk (clk), .rst_n (rst_n), .load (load),
      .x0 (x0), .y0 (y0), .z0 (z0), .w0 (w0),
      .start (start), .busy (busy), .key_valid (key_valid), .key (key),
      .x_o (x_o), .y_o (y_o), .z_o (z_o), .w_o (w_o)
   );

   // R1 product: bits [55:24] of the 64-bit signed product
   function automatic logic [31:0] bmul(input logic signed [31:0] a, input logic signed [31:0] b);
      logic signed [63:0] p;
      p = 64'(a) * 64'(b);
      return p[55:24];
   endfunction

   // R2 derivative
   function automatic v4_t bderiv(input v4_t v);
      v4_t r;
      r[0] = bmul(CA, v[1] - v[0]);
      r[1] = bmul(v[0], CB - v[2]) + v[3] - v[1];
      r[2] = bmul(v[0], v[1]) - bmul(CC, v[2]);
      r[3] = bmul(CD, v[0]);
      return r;
   endfunction

   // R3 step
   function automatic v4_t bstep(input v4_t s);
      v4_t k0, k1, k2, k3, q, r;
      k0 = bderiv(s);
      for (int i = 0; i < 4; i++) q[i] = s[i] + bmul(CHH, k0[i]);
      k1 = bderiv(q);
      for (int i = 0; i < 4; i++) q[i] = s[i] + bmul(CHH, k1[i]);
      k2 = bderiv(q);
      for (int i = 0; i < 4; i++) q[i] = s[i] + bmul(CH, k2[i]);
      k3 = bderiv(q);
      for (int i = 0; i < 4; i++)
         r[i] = s[i] + bmul(CH6, k0[i] + (k1[i] << 1) + (k2[i] << 1) + k3[i]);
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_state(input string tag);
      chk({tag, " x"}, x_o, model[0]);
      chk({tag, " y"}, y_o, model[1]);
      chk({tag, " z"}, z_o, model[2]);
      chk({tag, " w"}, w_o, model[3]);
   endtask

   task automatic do_load(input v4_t v);
      @(negedge clk);
      load = 1'b1;
      x0 = v[0]; y0 = v[1]; z0 = v[2]; w0 = v[3];
      @(negedge clk);
      load = 1'b0;
      model = v;
      chk_state("R8 load value");
      chk("R8 busy after load", 32'(busy), 32'd0);
   endtask

   // start one step; optional extra start in busy cycle 2 (R7)
   task automatic do_step(input bit extra_start);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R4 busy c1", 32'(busy), 32'd1);
      for (int c = 2; c <= 5; c++) begin
         if (extra_start && c == 2) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk("R4 busy mid", 32'(busy), 32'd1);
         chk("R10 no early valid", 32'(key_valid), 32'd0);
      end
      @(negedge clk);
      model = bstep(model);
      chk("R4 busy end", 32'(busy), 32'd0);
      chk("R4 valid end", 32'(key_valid), 32'd1);
      chk_state("R3 R6 state");
      chk("R5 key", 32'(key), 32'(model[0][23:0]));
      @(negedge clk);
      chk("R10 valid drop", 32'(key_valid), 32'd0);
      if (extra_start) chk("R7 no restart", 32'(busy), 32'd0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      v4_t v;
      void'($urandom(32'd20231207));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      model = '0;
      chk_state("R9 reset");
      chk("R9 busy", 32'(busy), 32'd0);
      chk("R9 valid", 32'(key_valid), 32'd0);

      // directed: unit conditions, chained steps (R6)
      do_load({32'h0100_0000, 32'h0100_0000, 32'h0100_0000, 32'h0100_0000});
      repeat (3) do_step(1'b0);

      // R11: idle hold with no start
      repeat (6) @(negedge clk);
      chk_state("R11 idle hold");

      // R1: extreme operands force wraparound
      do_load({32'h7FFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000});
      do_step(1'b0);
      do_step(1'b0);

      // R7: start while busy ignored
      do_load({32'hFA00_0000, 32'h0370_0000, 32'h1200_0000, 32'hFFF0_0000});
      do_step(1'b1);

      // R8: load aborts a running step
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      v = {32'h0011_2233, 32'h4455_6677, 32'h8899_AABB, 32'hCCDD_EEFF};
      load = 1'b1;
      x0 = v[0]; y0 = v[1]; z0 = v[2]; w0 = v[3];
      @(negedge clk);
      load = 1'b0;
      model = v;
      chk("R8 abort busy", 32'(busy), 32'd0);
      chk_state("R8 abort value");
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         chk("R8 no key after abort", 32'(key_valid), 32'd0);
      end
      chk_state("R8 state kept");
      do_step(1'b0);

      // R8: load beats start in the same cycle
      @(negedge clk);
      load = 1'b1; start = 1'b1;
      x0 = 32'h0200_0000; y0 = 32'h0; z0 = 32'h0300_0000; w0 = 32'h0;
      @(negedge clk);
      load = 1'b0; start = 1'b0;
      model = {32'h0, 32'h0300_0000, 32'h0, 32'h0200_0000};
      chk("R8 load wins", 32'(busy), 32'd0);
      chk_state("R8 load wins value");
      do_step(1'b0);

      // random initial conditions, chained steps
      for (int t = 0; t < 20; t++) begin
         do_load({$urandom(), $urandom(), $urandom(), $urandom()});
         for (int s = 0; s < 4; s++) do_step(1'b0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule